// File: doc/BRIEF.md
# Stereo Volume, Mute and De-emphasis Control

This block sits in the digital path of a stereo audio converter. It takes the left and right samples as they arrive with a valid strobe, and it returns a processed pair one clock later. The processing covers output routing, per-channel attenuation in half-decibel steps, and muting. It also produces the select code for a downstream de-emphasis filter and a flag that reports a long run of silence on the input. The filter itself is not part of this block.

Two control sources exist, and a mode input picks between them. In pin mode, a pair of de-emphasis pins is the only control and every other feature is fixed at its transparent value. In register mode, fields written through the setup port drive all of the features: mute, de-emphasis, routing, attenuation and silence detection.

Top module: `audio_ctl_path`

## Requirements
- R1: One clock after each cycle with `in_valid` high, `out_valid` is high and the outputs carry the processed pair. A cycle with `in_valid` low gives `out_valid` low one clock later, and the sample outputs keep their values.
- R2: After synchronous reset, `out_valid` is 0, both sample outputs are 0, `deemph_sel` is 00 and `zero_flag` is 0.
- R3: With `sw_mode` low, `deemph_sel` equals `hw_deemph` one clock later. The encoding is 00 off, 01 48 kHz, 10 44.1 kHz and 11 32 kHz.
- R4: With `sw_mode` high, `deemph_sel` equals `reg_deemph` one clock later, using the same encoding as R3.
- R5: With `sw_mode` low, every register field is ignored: the outputs equal the inputs with straight routing, unity gain and no mute, and `zero_flag` stays 0.
- R6: With `sw_mode` high and an attenuation code c below 255, the gain is M[c mod 12] / 2^(15 + c div 12), where M[k] = round(32768 * 10^(-k/40)). The output is floor(x * M / 2^(15 + c div 12)), so code 0 is exactly unity.
- R7: With `sw_mode` high, attenuation code 255 forces that output channel to 0.
- R8: With `sw_mode` high and `reg_mute` set, both outputs are 0 for the sample that arrives with it. When `reg_mute` clears, the next sample is processed normally.
- R9: `reg_route[1:0]` selects the left output source and `reg_route[3:2]` selects the right output source. The codes are 00 zero, 01 left input, 10 right input and 11 floor((L+R)/2). The left output uses `reg_att_left` and the right output uses `reg_att_right`.
- R10: With `sw_mode` and `reg_zero_en` high, `zero_flag` rises together with the output of the ZERO_RUN-th consecutive valid sample in which both inputs are zero. With the default ZERO_RUN of 1024 it is still 0 after the 1023rd such sample.
- R11: A valid sample with either input nonzero clears `zero_flag` at its output, and the run count starts again from zero.
- R12: With `reg_zero_en` low, `zero_flag` stays 0 no matter how long the input is silent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample pair strobe |
| in_left | input | SW | Left input sample, two's complement |
| in_right | input | SW | Right input sample, two's complement |
| sw_mode | input | 1 | 1 selects register control, 0 selects pin control |
| hw_deemph | input | 2 | De-emphasis pins used in pin mode |
| reg_mute | input | 1 | Register mute bit |
| reg_deemph | input | 2 | Register de-emphasis field |
| reg_zero_en | input | 1 | Register silence-detect enable |
| reg_route | input | 4 | Register routing field, [1:0] left output, [3:2] right output |
| reg_att_left | input | 8 | Left attenuation code |
| reg_att_right | input | 8 | Right attenuation code |
| out_valid | output | 1 | Output pair strobe |
| out_left | output | SW | Processed left sample |
| out_right | output | SW | Processed right sample |
| deemph_sel | output | 2 | Effective de-emphasis select code |
| zero_flag | output | 1 | Long-silence flag |

## Verification
The bench sets every register field to an active value in pin mode. A design that leaks even one field through would scale, swap or mute the output, or raise the silence flag. It tests attenuation on negative samples and on codes that cross the 12-step shift boundary. A design that rounds toward zero, or that gets the mantissa and shift split wrong, gives results off by one or by a factor of two. The silence run is checked at exactly 1023 and 1024 samples, which catches an off-by-one counter. A nonzero sample followed by a new run confirms that the count restarts, so a counter that only pauses would be caught. The averaging route is driven with an odd negative sum, where a design that truncates toward zero differs by one.

// File: rtl/actl_pkg.sv
package actl_pkg;

    localparam int ATT_W  = 8;
    localparam int MANT_W = 17;
    localparam int FRAC_W = 15;

    typedef enum logic [1:0] {
        DE_OFF = 2'b00,
        DE_48K = 2'b01,
        DE_44K = 2'b10,
        DE_32K = 2'b11
    } deemph_e;

    typedef enum logic [1:0] {
        SRC_NONE  = 2'b00,
        SRC_LEFT  = 2'b01,
        SRC_RIGHT = 2'b10,
        SRC_AVG   = 2'b11
    } route_e;

    typedef struct packed {
        logic             mute;
        logic             zero_en;
        deemph_e          de;
        route_e           src_l;
        route_e           src_r;
        logic [ATT_W-1:0] att_l;
        logic [ATT_W-1:0] att_r;
    } ctl_t;

    // Fractional gain mantissas, 0.5 dB apart, in Q15 (32768 = 1.0)
    function automatic logic [MANT_W-1:0] att_mant(input logic [3:0] k);
        case (k)
            4'd0:    att_mant = 17'd32768;
            4'd1:    att_mant = 17'd30935;
            4'd2:    att_mant = 17'd29205;
            4'd3:    att_mant = 17'd27571;
            4'd4:    att_mant = 17'd26029;
            4'd5:    att_mant = 17'd24573;
            4'd6:    att_mant = 17'd23198;
            4'd7:    att_mant = 17'd21900;
            4'd8:    att_mant = 17'd20675;
            4'd9:    att_mant = 17'd19519;
            4'd10:   att_mant = 17'd18427;
            4'd11:   att_mant = 17'd17396;
            default: att_mant = 17'd0;
        endcase
    endfunction

endpackage

// File: rtl/actl_ctl_mux.sv
module actl_ctl_mux
    import actl_pkg::*;
(
    input  logic             sw_mode,
    input  logic [1:0]       hw_deemph,
    input  logic             reg_mute,
    input  logic [1:0]       reg_deemph,
    input  logic             reg_zero_en,
    input  logic [3:0]       reg_route,
    input  logic [ATT_W-1:0] reg_att_left,
    input  logic [ATT_W-1:0] reg_att_right,
    output ctl_t             ctl
);
    always_comb begin
        if (sw_mode) begin
            ctl.mute    = reg_mute;
            ctl.zero_en = reg_zero_en;
            ctl.de      = deemph_e'(reg_deemph);
            ctl.src_l   = route_e'(reg_route[1:0]);
            ctl.src_r   = route_e'(reg_route[3:2]);
            ctl.att_l   = reg_att_left;
            ctl.att_r   = reg_att_right;
        end else begin
            ctl.mute    = 1'b0;
            ctl.zero_en = 1'b0;
            ctl.de      = deemph_e'(hw_deemph);
            ctl.src_l   = SRC_LEFT;
            ctl.src_r   = SRC_RIGHT;
            ctl.att_l   = '0;
            ctl.att_r   = '0;
        end
    end
endmodule

// File: rtl/actl_router.sv
module actl_router
    import actl_pkg::*;
#(
    parameter int SW = 18
) (
    input  logic signed [SW-1:0] l_in,
    input  logic signed [SW-1:0] r_in,
    input  route_e               src,
    output logic signed [SW-1:0] y
);
    logic signed [SW:0] sum;

    always_comb begin
        sum = {l_in[SW-1], l_in} + {r_in[SW-1], r_in};
        case (src)
            SRC_LEFT:  y = l_in;
            SRC_RIGHT: y = r_in;
            SRC_AVG:   y = sum[SW:1];
            default:   y = '0;
        endcase
    end
endmodule

// File: rtl/actl_atten.sv
module actl_atten
    import actl_pkg::*;
#(
    parameter int SW = 18
) (
    input  logic signed [SW-1:0] x,
    input  logic [ATT_W-1:0]     code,
    output logic signed [SW-1:0] y
);
    localparam int PW = SW + MANT_W;
    localparam logic signed [PW-1:0] MAXV = {{(PW-SW+1){1'b0}}, {(SW-1){1'b1}}};
    localparam logic signed [PW-1:0] MINV = {{(PW-SW+1){1'b1}}, {(SW-1){1'b0}}};

    logic [3:0]              frac_idx;
    logic [4:0]              oct;
    logic [MANT_W-1:0]       mant;
    logic signed [PW-1:0]    prod;
    logic signed [PW-1:0]    scaled;
    logic [5:0]              sh;

    always_comb begin
        frac_idx = 4'(code % 8'd12);
        oct      = 5'(code / 8'd12);
        mant     = att_mant(frac_idx);
        sh       = 6'd15 + {1'b0, oct};
        prod     = $signed({{MANT_W{x[SW-1]}}, x}) * $signed({{SW{1'b0}}, mant});
        scaled   = prod >>> sh;
        if (code == {ATT_W{1'b1}})
            y = '0;
        else if (scaled > MAXV)
            y = MAXV[SW-1:0];
        else if (scaled < MINV)
            y = MINV[SW-1:0];
        else
            y = scaled[SW-1:0];
    end
endmodule

// File: rtl/actl_zero_det.sv
module actl_zero_det #(
    parameter int SW       = 18,
    parameter int ZERO_RUN = 1024
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          valid,
    input  logic [SW-1:0] l_in,
    input  logic [SW-1:0] r_in,
    output logic          flag
);
    localparam int CW = $clog2(ZERO_RUN + 1);
    localparam logic [CW-1:0] RUN_C = CW'(ZERO_RUN);

    logic [CW-1:0] run_cnt;
    logic          silent;

    assign silent = (l_in == '0) && (r_in == '0);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            run_cnt <= '0;
            flag    <= 1'b0;
        end else if (valid) begin
            if (silent) begin
                if (run_cnt != RUN_C)
                    run_cnt <= run_cnt + 1'b1;
                flag <= (run_cnt >= RUN_C - 1'b1);
            end else begin
                run_cnt <= '0;
                flag    <= 1'b0;
            end
        end
    end

    // R12: no flag while detection is disabled
    a_r12_disabled_low: assert property (@(posedge clk) disable iff (rst)
        !en |=> !flag);

    // R11: any nonzero sample clears the flag
    a_r11_nonzero_clears: assert property (@(posedge clk) disable iff (rst)
        (en && valid && !silent) |=> !flag);
endmodule

// File: rtl/audio_ctl_path.sv
module audio_ctl_path
    import actl_pkg::*;
#(
    parameter int SW       = 18,
    parameter int ZERO_RUN = 1024
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic signed [SW-1:0] in_left,
    input  logic signed [SW-1:0] in_right,
    input  logic                 sw_mode,
    input  logic [1:0]           hw_deemph,
    input  logic                 reg_mute,
    input  logic [1:0]           reg_deemph,
    input  logic                 reg_zero_en,
    input  logic [3:0]           reg_route,
    input  logic [ATT_W-1:0]     reg_att_left,
    input  logic [ATT_W-1:0]     reg_att_right,
    output logic                 out_valid,
    output logic signed [SW-1:0] out_left,
    output logic signed [SW-1:0] out_right,
    output logic [1:0]           deemph_sel,
    output logic                 zero_flag
);
    localparam int NCH = 2;

    ctl_t                 ctl;
    route_e               src    [NCH];
    logic [ATT_W-1:0]     att    [NCH];
    logic signed [SW-1:0] routed [NCH];
    logic signed [SW-1:0] scaled [NCH];

    actl_ctl_mux u_ctl (
        .sw_mode      (sw_mode),
        .hw_deemph    (hw_deemph),
        .reg_mute     (reg_mute),
        .reg_deemph   (reg_deemph),
        .reg_zero_en  (reg_zero_en),
        .reg_route    (reg_route),
        .reg_att_left (reg_att_left),
        .reg_att_right(reg_att_right),
        .ctl          (ctl)
    );

    assign src[0] = ctl.src_l;
    assign src[1] = ctl.src_r;
    assign att[0] = ctl.att_l;
    assign att[1] = ctl.att_r;

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        actl_router #(.SW(SW)) u_route (
            .l_in (in_left),
            .r_in (in_right),
            .src  (src[ch]),
            .y    (routed[ch])
        );
        actl_atten #(.SW(SW)) u_att (
            .x    (routed[ch]),
            .code (att[ch]),
            .y    (scaled[ch])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            out_left   <= '0;
            out_right  <= '0;
            deemph_sel <= DE_OFF;
        end else begin
            out_valid  <= in_valid;
            deemph_sel <= ctl.de;
            if (in_valid) begin
                out_left  <= ctl.mute ? '0 : scaled[0];
                out_right <= ctl.mute ? '0 : scaled[1];
            end
        end
    end

    actl_zero_det #(.SW(SW), .ZERO_RUN(ZERO_RUN)) u_zero (
        .clk   (clk),
        .rst   (rst),
        .en    (ctl.zero_en),
        .valid (in_valid),
        .l_in  (in_left),
        .r_in  (in_right),
        .flag  (zero_flag)
    );

    // R1: strobe latency and hold
    a_r1_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    a_r1_hold_idle: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(out_left) && $stable(out_right)));

    // R3: pin de-emphasis passes through in pin mode
    a_r3_hw_deemph: assert property (@(posedge clk) disable iff (rst)
        !sw_mode |=> deemph_sel == $past(hw_deemph));

    // R5: pin mode is transparent
    a_r5_hw_transparent: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !sw_mode) |=> (out_left == $past(in_left) && out_right == $past(in_right)));

    // R7: full attenuation code silences the channel
    a_r7_full_att_zero: assert property (@(posedge clk) disable iff (rst)
        (in_valid && sw_mode && reg_att_left == {ATT_W{1'b1}}) |=> out_left == '0);

    // R8: mute silences both channels
    a_r8_mute_zero: assert property (@(posedge clk) disable iff (rst)
        (in_valid && sw_mode && reg_mute) |=> (out_left == '0 && out_right == '0));
endmodule

// File: tb/audio_ctl_path_tb.sv
module audio_ctl_path_tb;
    localparam int SW  = 18;
    localparam int RUN = 1024;

    logic                 clk = 1'b0;
    logic                 rst;
    logic                 in_valid;
    logic signed [SW-1:0] in_left, in_right;
    logic                 sw_mode;
    logic [1:0]           hw_deemph;
    logic                 reg_mute;
    logic [1:0]           reg_deemph;
    logic                 reg_zero_en;
    logic [3:0]           reg_route;
    logic [7:0]           reg_att_left, reg_att_right;
    logic                 out_valid;
    logic signed [SW-1:0] out_left, out_right;
    logic [1:0]           deemph_sel;
    logic                 zero_flag;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    audio_ctl_path #(.SW(SW), .ZERO_RUN(RUN)) u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_left(in_left), .in_right(in_right),
        .sw_mode(sw_mode), .hw_deemph(hw_deemph), .reg_mute(reg_mute), .reg_deemph(reg_deemph),
        .reg_zero_en(reg_zero_en), .reg_route(reg_route), .reg_att_left(reg_att_left),
        .reg_att_right(reg_att_right), .out_valid(out_valid), .out_left(out_left),
        .out_right(out_right), .deemph_sel(deemph_sel), .zero_flag(zero_flag)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint mant_of(input int k);
        real g;
        g = 32768.0 * (10.0 ** (-k / 40.0));
        return longint'($rtoi(g + 0.5));
    endfunction

    function automatic longint exp_att(input longint x, input int code);
        longint p;
        if (code == 255) return 0;
        p = x * mant_of(code % 12);
        return p >>> (15 + code / 12);
    endfunction

    function automatic longint exp_route(input longint l, input longint r, input int sel);
        case (sel)
            1: return l;
            2: return r;
            3: return (l + r) >>> 1;
            default: return 0;
        endcase
    endfunction

    task automatic sw_defaults();
        reg_mute = 0; reg_deemph = 2'b00; reg_zero_en = 0;
        reg_route = 4'b1001; reg_att_left = 0; reg_att_right = 0;
    endtask

    // drive one sample; on return outputs reflect it
    task automatic send(input longint l, input longint r);
        @(negedge clk);
        in_valid = 1; in_left = SW'(l); in_right = SW'(r);
        @(negedge clk);
        in_valid = 0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R2 out_valid", out_valid, 0);
        chk("R2 out_left", out_left, 0);
        chk("R2 out_right", out_right, 0);
        chk("R2 deemph_sel", deemph_sel, 0);
        chk("R2 zero_flag", zero_flag, 0);
    endtask

    task automatic t_valid();
        sw_mode = 1; sw_defaults();
        send(1234, -567);
        chk("R1 out_valid", out_valid, 1);
        chk("R1 left", out_left, 1234);
        chk("R1 right", out_right, -567);
        in_left = 99; in_right = 99;
        @(negedge clk);
        chk("R1 idle valid", out_valid, 0);
        chk("R1 hold left", out_left, 1234);
        chk("R1 hold right", out_right, -567);
    endtask

    task automatic t_hw_deemph();
        sw_mode = 0; reg_deemph = 2'b00;
        for (int c = 0; c < 4; c++) begin
            @(negedge clk); hw_deemph = 2'(c);
            @(negedge clk);
            chk("R3 pin deemph", deemph_sel, c);
        end
    endtask

    task automatic t_sw_deemph();
        sw_mode = 1; sw_defaults(); hw_deemph = 2'b11;
        for (int c = 0; c < 4; c++) begin
            @(negedge clk); reg_deemph = 2'(c);
            @(negedge clk);
            chk("R4 reg deemph", deemph_sel, c);
        end
    endtask

    task automatic t_hw_ignore();
        sw_mode = 0; hw_deemph = 2'b00;
        reg_mute = 1; reg_zero_en = 1; reg_route = 4'b0110;
        reg_att_left = 8'd40; reg_att_right = 8'd255;
        send(-70000, 45000);
        chk("R5 left", out_left, -70000);
        chk("R5 right", out_right, 45000);
        for (int i = 0; i < 20; i++) send(0, 0);
        chk("R5 zero_flag", zero_flag, 0);
    endtask

    task automatic t_atten();
        int codes [8] = '{0, 1, 6, 11, 12, 13, 100, 254};
        longint vals [3] = '{131071, -131072, -12345};
        sw_mode = 1; sw_defaults();
        foreach (codes[i]) foreach (vals[j]) begin
            reg_att_left = 8'(codes[i]); reg_att_right = 8'(codes[(i + 3) % 8]);
            send(vals[j], -vals[j] - 1);
            chk("R6 left att", out_left, exp_att(vals[j], codes[i]));
            chk("R6 right att", out_right, exp_att(-vals[j] - 1, codes[(i + 3) % 8]));
        end
        reg_att_left = 8'd255; reg_att_right = 8'd0;
        send(100000, 100000);
        chk("R7 left zero", out_left, 0);
        chk("R7 right pass", out_right, 100000);
        reg_att_left = 8'd0; reg_att_right = 8'd255;
        send(-3, -131072);
        chk("R7 right zero", out_right, 0);
        chk("R7 left pass", out_left, -3);
        sw_defaults();
    endtask

    task automatic t_mute();
        sw_mode = 1; sw_defaults(); reg_mute = 1;
        send(5000, -5000);
        chk("R8 muted left", out_left, 0);
        chk("R8 muted right", out_right, 0);
        reg_mute = 0;
        send(5000, -5000);
        chk("R8 unmuted left", out_left, 5000);
        chk("R8 unmuted right", out_right, -5000);
    endtask

    task automatic t_route();
        sw_mode = 1; sw_defaults();
        for (int a = 0; a < 4; a++) begin
            for (int b = 0; b < 4; b++) begin
                reg_route = 4'((b << 2) | a);
                send(-1001, 2);
                chk("R9 left route", out_left, exp_route(-1001, 2, a));
                chk("R9 right route", out_right, exp_route(-1001, 2, b));
            end
        end
        reg_route = 4'b1111; reg_att_left = 8'd12; reg_att_right = 8'd0;
        send(40001, 20000);
        chk("R9 avg with left att", out_left, exp_att(30000, 12));
        chk("R9 avg right", out_right, 30000);
        sw_defaults();
    endtask

    task automatic t_zero();
        sw_mode = 1; sw_defaults(); reg_zero_en = 1;
        @(negedge clk);
        in_valid = 1; in_left = 0; in_right = 0;
        repeat (RUN - 1) @(negedge clk);
        chk("R10 not yet", zero_flag, 0);
        @(negedge clk);
        chk("R10 asserted", zero_flag, 1);
        in_left = 1;
        @(negedge clk);
        chk("R11 cleared", zero_flag, 0);
        in_left = 0; in_right = 0;
        repeat (RUN - 1) @(negedge clk);
        chk("R11 restart count", zero_flag, 0);
        @(negedge clk);
        chk("R11 reasserted", zero_flag, 1);
        in_right = -1;
        @(negedge clk);
        chk("R11 right clears", zero_flag, 0);
        in_valid = 0;
    endtask

    task automatic t_zero_dis();
        sw_mode = 1; sw_defaults(); reg_zero_en = 0;
        @(negedge clk);
        in_valid = 1; in_left = 0; in_right = 0;
        repeat (RUN + 10) @(negedge clk);
        in_valid = 0;
        chk("R12 disabled", zero_flag, 0);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        rst = 1; in_valid = 0; in_left = 0; in_right = 0;
        sw_mode = 0; hw_deemph = 0; sw_defaults();
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        t_reset();
        t_valid();
        t_hw_deemph();
        t_sw_deemph();
        t_hw_ignore();
        t_atten();
        t_mute();
        t_route();
        t_zero();
        t_zero_dis();
        finish_run();
    end
endmodule